// File: doc/BRIEF.md
# Dual-Channel RC-Timing Potentiometer Digitizer

This block turns the positions of two potentiometers into 8-bit numbers. Each potentiometer charges an external capacitor. An external comparator reports when the voltage on that line crosses a fixed threshold, and the block measures how long that takes.

One shared 9-bit counter advances on each enable tick. Its top bit splits every 512-tick period into two halves. In the first half both lines are free to charge, and each channel copies the counter's low byte when its comparator fires. In the second half both lines are clamped to ground. At the wrap from 511 to 0 the clamps let go and timing starts again, with no separate settling wait.

A channel whose comparator never fires during the charge half reads full scale. Software selects a channel with a one-bit address and reads its last captured value.

Top module: `pot_rc_digitizer`

## Requirements
- R1: The 9-bit count advances by one on every clock edge where `tick` is high, holds otherwise, and wraps from 511 to 0, so the clamp pattern repeats every 512 ticks.
- R2: Each clamp output equals bit 8 of the count: high for counts 256 to 511 and low for counts 0 to 255. It rises on the tick that moves the count from 255 to 256.
- R3: While `rst_n` is low, both clamps are high. Reset clears the count to 0, so both clamps go low as soon as reset ends. Reset also clears both position registers to 0.
- R4: Each comparator input passes through two synchronizer flops. On the third clock edge after a rising comparator input, the channel stores the count's low 8 bits.
- R5: Both channels share one counter and are timed at the same time. Their clamps always carry the same value, and each channel's capture depends only on its own comparator.
- R6: Within one charge period, only the first synchronized rising edge on a channel is stored. Any later rising edge on that channel before the next wrap to 0 leaves its register unchanged.
- R7: If a channel has stored nothing by the tick that takes the count from 255 to 256, its register is loaded with 255 on that tick.
- R8: A position register keeps its value between captures. It changes only while the count is in the charge half, or on the tick that closes that half.
- R9: `rd_data` returns channel 0's register when `rd_sel` is 0 and channel 1's register when `rd_sel` is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one pulse per measurement step |
| cmp_a | input | 1 | Threshold comparator output, channel 0 (asynchronous) |
| cmp_b | input | 1 | Threshold comparator output, channel 1 (asynchronous) |
| clamp_a | output | 1 | Ground clamp enable, channel 0 line |
| clamp_b | output | 1 | Ground clamp enable, channel 1 line |
| rd_sel | input | 1 | Read channel select |
| rd_data | output | 8 | Selected channel position |

## Verification
The assertions take three things for granted. A comparator input stays low while its line is clamped. Once it rises, it stays high long enough to pass the synchronizer. And ticks come at least four clocks apart, so the count is still at the crossing value when the capture lands.

The stimulus keeps to this. Ticks are driven every fourth clock. Each comparator is modelled as going high a chosen number of ticks after release and dropping as soon as the clamp engages. Some channels get an extra low pulse lasting two ticks after the first crossing.

Delays are drawn from a fixed-seed random source that reaches past 255, alongside directed delays of 0, 1, 254, 255 and 256 and values that never fire.

// File: rtl/pot_rc_digitizer.sv
module pot_rc_digitizer #(
  parameter int POS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp_a,
  input  logic             cmp_b,
  output logic             clamp_a,
  output logic             clamp_b,
  input  logic             rd_sel,
  output logic [POS_W-1:0] rd_data
);
  localparam int CNT_W = POS_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic             discharge;
  logic             win_end;
  logic             win_start;
  logic [1:0]       cmp_raw;
  logic [SYNC_STAGES-1:0] sync_q [2];
  logic [1:0]       prev_q;
  logic [1:0]       rise;
  logic [1:0]       done_q;
  logic [POS_W-1:0] pos_q [2];
  logic [POS_W-1:0] pos_a;
  logic [POS_W-1:0] pos_b;
  logic             done_a;
  logic             done_b;

  assign discharge = cnt[CNT_W-1];
  assign clamp_a   = discharge | ~rst_n;
  assign clamp_b   = discharge | ~rst_n;
  assign win_end   = tick && !discharge && (cnt[POS_W-1:0] == POS_MAX);
  assign win_start = tick && (cnt == CNT_LAST);
  assign cmp_raw   = {cmp_b, cmp_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_comb begin
    for (int ch = 0; ch < 2; ch++)
      rise[ch] = sync_q[ch][SYNC_STAGES-1] & ~prev_q[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        sync_q[ch] <= '0;
        pos_q[ch]  <= '0;
      end
      prev_q <= '0;
      done_q <= '0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        sync_q[ch] <= {sync_q[ch][SYNC_STAGES-2:0], cmp_raw[ch]};
        prev_q[ch] <= sync_q[ch][SYNC_STAGES-1];
        if (win_start) begin
          done_q[ch] <= 1'b0;
        end else if (rise[ch] && !done_q[ch]) begin
          pos_q[ch]  <= cnt[POS_W-1:0];
          done_q[ch] <= 1'b1;
        end else if (win_end && !done_q[ch]) begin
          pos_q[ch]  <= POS_MAX;
          done_q[ch] <= 1'b1;
        end
      end
    end
  end

  assign pos_a   = pos_q[0];
  assign pos_b   = pos_q[1];
  assign done_a  = done_q[0];
  assign done_b  = done_q[1];
  assign rd_data = rd_sel ? pos_b : pos_a;
endmodule

// File: rtl/pot_rc_digitizer_chk.sv
module pot_rc_digitizer_chk #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [POS_W:0]   cnt,
  input logic             clamp_a,
  input logic             clamp_b,
  input logic             done_a,
  input logic             done_b,
  input logic [POS_W-1:0] pos_a,
  input logic [POS_W-1:0] pos_b
);
  localparam logic [POS_W:0] CNT_HALF = 1 << POS_W;
  localparam logic [POS_W:0] CNT_LAST = '1;
  localparam logic [POS_W:0] CNT_TOP  = (1 << POS_W) - 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_clamp_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_a) |-> cnt == CNT_HALF);

  assert_clamp_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_a) |-> cnt == '0);

  assert_clamps_match_R5: assert property (@(posedge clk)
    clamp_a == clamp_b);

  assert_single_capture_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_a) && !$past(tick && cnt == CNT_LAST)) |-> $stable(pos_a));

  assert_single_capture_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_b) && !$past(tick && cnt == CNT_LAST)) |-> $stable(pos_b));

  assert_full_scale_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == CNT_TOP && !done_a) |=> pos_a == POS_MAX);

  assert_full_scale_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == CNT_TOP && !done_b) |=> pos_b == POS_MAX);

  assert_hold_in_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pos_a) || !$stable(pos_b)) |-> !$past(cnt[POS_W]));
endmodule

bind pot_rc_digitizer pot_rc_digitizer_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
  .clamp_a(clamp_a), .clamp_b(clamp_b),
  .done_a(done_a), .done_b(done_b),
  .pos_a(pos_a), .pos_b(pos_b)
);

// File: tb/pot_rc_digitizer_tb.sv
module pot_rc_digitizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WINDOWS    = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cmp_a = 1'b0;
  logic       cmp_b = 1'b0;
  logic       rd_sel = 1'b0;
  logic       clamp_a, clamp_b;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;

  logic [8:0] model_cnt = '0;
  int  dly [2];
  bit  glitch [2];
  int  prev_exp [2];
  int  cyc = 0;
  int  tick_idx = 0;
  int  last_release = -1;

  pot_rc_digitizer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .clamp_a(clamp_a), .clamp_b(clamp_b), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_pos(input int d);
    return (d > 255) ? 255 : d;
  endfunction

  function automatic logic cmp_model(input logic [8:0] c, input int d, input bit g);
    int lo;
    lo = int'(c[7:0]);
    if (c[8]) return 1'b0;
    if (lo < d) return 1'b0;
    if (g && (lo == d + 2 || lo == d + 3)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic read_ch(input bit ch, output int v);
    rd_sel = ch;
    #1;
    v = int'(rd_data);
  endtask

  task automatic pick_delays(input int w);
    case (w)
      0: begin dly[0] = 128; dly[1] = 40;  glitch[0] = 0; glitch[1] = 0; end
      1: begin dly[0] = 0;   dly[1] = 255; glitch[0] = 0; glitch[1] = 0; end
      2: begin dly[0] = 256; dly[1] = 300; glitch[0] = 0; glitch[1] = 0; end
      3: begin dly[0] = 1;   dly[1] = 254; glitch[0] = 1; glitch[1] = 0; end
      4: begin dly[0] = 200; dly[1] = 10;  glitch[0] = 1; glitch[1] = 1; end
      default: begin
        for (int ch = 0; ch < 2; ch++) begin
          dly[ch]    = int'($urandom % 320);
          glitch[ch] = bit'($urandom % 2);
        end
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int v;
    int win;
    void'($urandom(32'h5eed_0042));
    pick_delays(0);
    win = 0;
    repeat (3) @(negedge clk);
    check("R3 clamp_a in reset", int'(clamp_a), 1);
    check("R3 clamp_b in reset", int'(clamp_b), 1);
    read_ch(0, v); check("R3 ch0 reset value", v, 0);
    read_ch(1, v); check("R3 ch1 reset value", v, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R3 clamp_a after reset", int'(clamp_a), 0);
    check("R3 clamp_b after reset", int'(clamp_b), 0);
    cmp_a = cmp_model(model_cnt, dly[0], glitch[0]);
    cmp_b = cmp_model(model_cnt, dly[1], glitch[1]);
    prev_exp[0] = 0;
    prev_exp[1] = 0;

    while (win < WINDOWS) begin
      @(negedge clk);
      if (tick) begin
        model_cnt = model_cnt + 1'b1;
        tick_idx++;
        check("R2 clamp_a vs count", int'(clamp_a), int'(model_cnt[8]));
        check("R5 clamp_b vs count", int'(clamp_b), int'(model_cnt[8]));
        if (model_cnt == 9'd0) begin
          if (last_release >= 0)
            check("R1 period in ticks", tick_idx - last_release, 512);
          last_release = tick_idx;
        end
        if (model_cnt == 9'd2) begin
          if (dly[0] >= 3) begin
            read_ch(0, v); check("R8 ch0 holds before capture", v, prev_exp[0]);
          end
          if (dly[1] >= 3) begin
            read_ch(1, v); check("R8 ch1 holds before capture", v, prev_exp[1]);
          end
        end
        if (model_cnt == 9'd300) begin
          read_ch(0, v);
          if (dly[0] > 255) check("R7 ch0 full scale", v, 255);
          else if (glitch[0]) check("R6 ch0 first edge only", v, dly[0]);
          else check("R4 ch0 capture", v, exp_pos(dly[0]));
          read_ch(1, v);
          if (dly[1] > 255) check("R7 ch1 full scale", v, 255);
          else if (glitch[1]) check("R6 ch1 first edge only", v, dly[1]);
          else check("R5 ch1 capture", v, exp_pos(dly[1]));
          read_ch(0, v); check("R9 select ch0", v, exp_pos(dly[0]));
          prev_exp[0] = exp_pos(dly[0]);
          prev_exp[1] = exp_pos(dly[1]);
          win++;
          pick_delays(win);
        end
      end
      cmp_a = cmp_model(model_cnt, dly[0], glitch[0]);
      cmp_b = cmp_model(model_cnt, dly[1], glitch[1]);
      cyc++;
      tick = ((cyc % TICK_DIV) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule